// File: doc/BRIEF.md
# Cell-Bus Transmit Port (PHY Side, Single Status Line, Byte Wide)

This block is the physical-layer end of a multi-PHY cell bus in the transmit direction. An upstream cell-layer master polls it by placing a 5-bit address on a shared address bus. It selects the port for transfer and then pushes fixed 53-byte cells, one byte per clock. An active-low enable qualifies the bytes, and a start-of-cell flag marks the first byte. The port compares each address against its own configured port number. It answers a poll with a registered cell-space flag and an output-enable for that flag, and the chip-level pad uses the enable to float the shared status line. A second flag reports room for two cells. That flag is never floated.

Cells land in an internal buffer that holds up to four cell slots. Its usable depth is chosen at run time as two, three or four cells. A cell becomes visible downstream only once all of its bytes are in. If a new start-of-cell arrives while a cell is only partly received, the port drops the partial cell and restarts on the new first byte. If a cell begins while no slot is free, the port discards the whole cell and sets a sticky overflow flag. The framer side drains whole cells through a valid/ready byte stream. A byte moves only in a cycle where both valid and ready are high. Valid stays high and data and first-byte flag hold steady while ready is low, so the consumer can stall at any byte without loss.

Top module: `utp2_tx_phy`

## Requirements
- R1: During reset and on the first cycle after it, the status flag and its output-enable, the two-cell flag, the read-valid output and the overflow flag are all 0. Reset also empties the buffer and drops any partial cell.
- R2: One clock after a cycle in which the address bus equals the configured port address, the output-enable is 1. The status flag is then 1 exactly when at least one whole cell of space was free in that polled cycle.
- R3: One clock after a cycle in which the address bus differs from the configured port address, the output-enable is 0 and the status flag is 0.
- R4: The two-cell flag is registered with the same one-clock timing. It is 1 exactly when at least two whole cells of space are free, and it does not depend on the polled address.
- R5: Depth code 2'b00 gives 2 cells, 2'b01 gives 3 cells, and 2'b10 or 2'b11 gives 4 cells. Free space is the depth minus the stored cells minus one slot for a cell in progress, never below zero.
- R6: A cell is held back from the read stream until its 53rd byte is taken. Read-valid rises on the clock edge that takes that byte.
- R7: Bytes are taken only while enable is low and the port is selected. The port is selected when, in the last cycle before the enable went low, the address bus matched. Transfers meant for another address leave the buffer unchanged.
- R8: A start-of-cell that arrives before the current cell has all 53 bytes discards the partial cell. Reception restarts with that byte as byte 0.
- R9: A start-of-cell taken while the buffer already holds as many cells as the depth sets the overflow flag. The flag then stays 1 until reset, the whole cell is dropped, and the stored cells are left unchanged.
- R10: The read stream gives cells in arrival order, bytes in order, with the first-byte flag high only on byte 0. A byte is consumed in a cycle where valid and ready are both 1. While ready is 0, valid, data and first-byte flag hold.
- R11: Cycles with the enable high in the middle of a cell add no byte and leave the partial cell intact. The next enabled byte continues the same cell.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Transmit bus clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cfg_port_addr | input | 5 | Configured port address, 0 to 31 |
| cfg_depth | input | 2 | Buffer depth code (00: 2, 01: 3, 1x: 4 cells) |
| tx_addr | input | 5 | Polling and selection address from the master |
| tx_enb_n | input | 1 | Active-low byte enable |
| tx_soc | input | 1 | Start-of-cell, high on byte 0 |
| tx_data | input | 8 | Cell byte |
| tx_clav | output | 1 | Registered one-cell space flag |
| tx_clav_oe | output | 1 | Drive enable for the shared status line |
| tx_clav2 | output | 1 | Registered two-cell space flag, always driven |
| rd_valid | output | 1 | A stored byte is offered downstream |
| rd_ready | input | 1 | Downstream accepts the offered byte |
| rd_data | output | 8 | Offered byte |
| rd_soc | output | 1 | Offered byte is byte 0 of its cell |
| ovf_sticky | output | 1 | A cell was discarded for lack of space |

## Verification
Full cells with distinct byte patterns are sent to the matched address, and the read stream must return each one unaltered in order. A second pattern is sent after a selection cycle that names another address and must leave no trace. This separates address filtering from plain buffering. A truncated cell followed by a fresh start-of-cell must return only the fresh pattern, which separates realignment from appending. Filling each depth setting and then offering one more cell shows that the space flags, the rejection and the sticky flag all follow the selected depth. A consumer that stalls at the first byte and again mid-cell shows that the stream holds its data under back-pressure.

// File: rtl/utp_tx_pkg.sv
package utp_tx_pkg;

  localparam int unsigned UTP_CELL_BYTES = 53;

  typedef enum logic [1:0] {
    DEPTH_TWO   = 2'b00,
    DEPTH_THREE = 2'b01,
    DEPTH_FOUR  = 2'b10
  } depth_code_e;

  function automatic logic [2:0] depth_cells(input logic [1:0] code);
    case (code)
      DEPTH_TWO:   return 3'd2;
      DEPTH_THREE: return 3'd3;
      default:     return 3'd4;
    endcase
  endfunction

endpackage

// File: rtl/utp_tx_poll.sv
module utp_tx_poll #(
  parameter int unsigned PA_W  = 5,
  parameter int unsigned CNT_W = 3
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [PA_W-1:0]  bus_addr,
  input  logic [PA_W-1:0]  own_addr,
  input  logic             enb_n,
  input  logic [CNT_W:0]   free_cells,
  output logic             clav,
  output logic             clav_oe,
  output logic             clav2,
  output logic             selected
);

  logic hit;
  assign hit = (bus_addr == own_addr);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      clav     <= 1'b0;
      clav_oe  <= 1'b0;
      clav2    <= 1'b0;
      selected <= 1'b0;
    end else begin
      clav_oe <= hit;
      clav    <= hit && (free_cells != '0);
      clav2   <= (free_cells >= (CNT_W+1)'(2));
      if (enb_n) selected <= hit;
    end
  end

endmodule

// File: rtl/utp_tx_wr.sv
module utp_tx_wr #(
  parameter int unsigned CELL_B  = 53,
  parameter int unsigned SLOTS   = 4,
  parameter int unsigned CNT_W   = 3,
  parameter int unsigned MEM_AW  = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              enb_n,
  input  logic              soc,
  input  logic              selected,
  input  logic [CNT_W-1:0]  cells_held,
  input  logic [CNT_W-1:0]  depth,
  output logic              wr_en,
  output logic [MEM_AW-1:0] wr_addr,
  output logic              commit,
  output logic              partial,
  output logic              ovf
);

  localparam int unsigned BYTE_W = $clog2(CELL_B);
  localparam int unsigned SLOT_W = (SLOTS > 1) ? $clog2(SLOTS) : 1;
  localparam logic [BYTE_W-1:0] LAST_B = BYTE_W'(CELL_B - 1);
  localparam logic [SLOT_W-1:0] LAST_S = SLOT_W'(SLOTS - 1);

  logic [BYTE_W-1:0] byte_idx;
  logic [SLOT_W-1:0] slot;
  logic              take, room, last;
  logic [BYTE_W-1:0] wr_byte;

  assign take    = !enb_n && selected;
  assign room    = (cells_held < depth);
  assign last    = (byte_idx == LAST_B);
  assign wr_byte = soc ? '0 : byte_idx;
  assign wr_en   = take && (soc ? room : partial);
  assign commit  = take && !soc && partial && last;
  assign wr_addr = MEM_AW'(slot) * MEM_AW'(CELL_B) + MEM_AW'(wr_byte);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      partial  <= 1'b0;
      byte_idx <= '0;
      slot     <= '0;
      ovf      <= 1'b0;
    end else if (take) begin
      if (soc) begin
        if (room) begin
          partial  <= 1'b1;
          byte_idx <= BYTE_W'(1);
        end else begin
          partial  <= 1'b0;
          byte_idx <= '0;
          ovf      <= 1'b1;
        end
      end else if (partial) begin
        if (last) begin
          partial  <= 1'b0;
          byte_idx <= '0;
          slot     <= (slot == LAST_S) ? '0 : slot + SLOT_W'(1);
        end else begin
          byte_idx <= byte_idx + BYTE_W'(1);
        end
      end
    end
  end

endmodule

// File: rtl/utp_tx_store.sv
module utp_tx_store #(
  parameter int unsigned CELL_B = 53,
  parameter int unsigned SLOTS  = 4,
  parameter int unsigned DW     = 8,
  parameter int unsigned CNT_W  = 3,
  parameter int unsigned MEM_AW = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_en,
  input  logic [MEM_AW-1:0] wr_addr,
  input  logic [DW-1:0]     wr_data,
  input  logic              commit,
  output logic [CNT_W-1:0]  cells_held,
  output logic              rd_valid,
  input  logic              rd_ready,
  output logic [DW-1:0]     rd_data,
  output logic              rd_soc
);

  localparam int unsigned DEPTH_B = CELL_B * SLOTS;
  localparam int unsigned BYTE_W  = $clog2(CELL_B);
  localparam int unsigned SLOT_W  = (SLOTS > 1) ? $clog2(SLOTS) : 1;
  localparam logic [BYTE_W-1:0] LAST_B = BYTE_W'(CELL_B - 1);
  localparam logic [SLOT_W-1:0] LAST_S = SLOT_W'(SLOTS - 1);

  logic [DW-1:0]     mem [DEPTH_B];
  logic [SLOT_W-1:0] rd_slot;
  logic [BYTE_W-1:0] rd_byte;
  logic [MEM_AW-1:0] rd_addr;
  logic              pop, pop_end;

  assign rd_valid = (cells_held != '0);
  assign rd_addr  = MEM_AW'(rd_slot) * MEM_AW'(CELL_B) + MEM_AW'(rd_byte);
  assign rd_data  = mem[rd_addr];
  assign rd_soc   = rd_valid && (rd_byte == '0);
  assign pop      = rd_valid && rd_ready;
  assign pop_end  = pop && (rd_byte == LAST_B);

  always_ff @(posedge clk) begin
    if (wr_en) mem[wr_addr] <= wr_data;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      cells_held <= '0;
      rd_slot    <= '0;
      rd_byte    <= '0;
    end else begin
      case ({commit, pop_end})
        2'b10:   cells_held <= cells_held + CNT_W'(1);
        2'b01:   cells_held <= cells_held - CNT_W'(1);
        default: cells_held <= cells_held;
      endcase
      if (pop) begin
        if (pop_end) begin
          rd_byte <= '0;
          rd_slot <= (rd_slot == LAST_S) ? '0 : rd_slot + SLOT_W'(1);
        end else begin
          rd_byte <= rd_byte + BYTE_W'(1);
        end
      end
    end
  end

endmodule

// File: rtl/utp2_tx_phy.sv
module utp2_tx_phy
  import utp_tx_pkg::*;
#(
  parameter int unsigned PA_W   = 5,
  parameter int unsigned DW     = 8,
  parameter int unsigned CELL_B = UTP_CELL_BYTES,
  parameter int unsigned SLOTS  = 4
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic [PA_W-1:0] cfg_port_addr,
  input  logic [1:0]      cfg_depth,
  input  logic [PA_W-1:0] tx_addr,
  input  logic            tx_enb_n,
  input  logic            tx_soc,
  input  logic [DW-1:0]   tx_data,
  output logic            tx_clav,
  output logic            tx_clav_oe,
  output logic            tx_clav2,
  output logic            rd_valid,
  input  logic            rd_ready,
  output logic [DW-1:0]   rd_data,
  output logic            rd_soc,
  output logic            ovf_sticky
);

  localparam int unsigned CNT_W  = $clog2(SLOTS + 1);
  localparam int unsigned MEM_AW = $clog2(CELL_B * SLOTS);

  logic [CNT_W-1:0]  cells_held, depth_n;
  logic [CNT_W:0]    occupied, free_cells;
  logic              selected, wr_en, commit, partial;
  logic [MEM_AW-1:0] wr_addr;
  logic [2:0]        depth_raw;

  assign depth_raw  = depth_cells(cfg_depth);
  assign depth_n    = (32'(depth_raw) > SLOTS) ? CNT_W'(SLOTS) : CNT_W'(depth_raw);
  assign occupied   = (CNT_W+1)'(cells_held) + (CNT_W+1)'(partial);
  assign free_cells = ((CNT_W+1)'(depth_n) > occupied)
                      ? (CNT_W+1)'(depth_n) - occupied : '0;

  utp_tx_poll #(.PA_W(PA_W), .CNT_W(CNT_W)) u_poll (
    .clk(clk), .rst_n(rst_n), .bus_addr(tx_addr), .own_addr(cfg_port_addr),
    .enb_n(tx_enb_n), .free_cells(free_cells), .clav(tx_clav),
    .clav_oe(tx_clav_oe), .clav2(tx_clav2), .selected(selected)
  );

  utp_tx_wr #(.CELL_B(CELL_B), .SLOTS(SLOTS), .CNT_W(CNT_W), .MEM_AW(MEM_AW)) u_wr (
    .clk(clk), .rst_n(rst_n), .enb_n(tx_enb_n), .soc(tx_soc),
    .selected(selected), .cells_held(cells_held), .depth(depth_n),
    .wr_en(wr_en), .wr_addr(wr_addr), .commit(commit), .partial(partial),
    .ovf(ovf_sticky)
  );

  utp_tx_store #(.CELL_B(CELL_B), .SLOTS(SLOTS), .DW(DW), .CNT_W(CNT_W),
                 .MEM_AW(MEM_AW)) u_store (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_addr(wr_addr),
    .wr_data(tx_data), .commit(commit), .cells_held(cells_held),
    .rd_valid(rd_valid), .rd_ready(rd_ready), .rd_data(rd_data),
    .rd_soc(rd_soc)
  );

endmodule

// File: rtl/utp2_tx_phy_chk.sv
module utp2_tx_phy_chk #(
  parameter int unsigned PA_W = 5,
  parameter int unsigned DW   = 8
) (
  input logic            clk,
  input logic            rst_n,
  input logic [PA_W-1:0] cfg_port_addr,
  input logic [PA_W-1:0] tx_addr,
  input logic            tx_clav,
  input logic            tx_clav_oe,
  input logic            rd_valid,
  input logic            rd_ready,
  input logic [DW-1:0]   rd_data,
  input logic            rd_soc,
  input logic            ovf_sticky
);

  // R3: a poll of another address floats the status line next cycle
  assert_oe_miss_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (tx_addr != cfg_port_addr) |=> !tx_clav_oe);

  // R2: the status flag is only ever high while it is driven
  assert_clav_driven_R2: assert property (@(posedge clk) disable iff (!rst_n)
    tx_clav |-> tx_clav_oe);

  // R9: overflow stays set until reset
  assert_ovf_sticky_R9: assert property (@(posedge clk) disable iff (!rst_n)
    ovf_sticky |=> ovf_sticky);

  // R10: a stalled byte holds its value and flag
  assert_stall_hold_R10: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_valid && !rd_ready) |=> (rd_valid && $stable(rd_data) && $stable(rd_soc)));

  // R10: first-byte flag only with a valid byte
  assert_soc_valid_R10: assert property (@(posedge clk) disable iff (!rst_n)
    rd_soc |-> rd_valid);

endmodule

bind utp2_tx_phy utp2_tx_phy_chk #(.PA_W(PA_W), .DW(DW)) u_chk (
  .clk(clk), .rst_n(rst_n), .cfg_port_addr(cfg_port_addr), .tx_addr(tx_addr),
  .tx_clav(tx_clav), .tx_clav_oe(tx_clav_oe), .rd_valid(rd_valid),
  .rd_ready(rd_ready), .rd_data(rd_data), .rd_soc(rd_soc),
  .ovf_sticky(ovf_sticky)
);

// File: tb/utp2_tx_phy_bench.sv
module utp2_tx_phy_bench;

  localparam int CLK_PERIOD = 10;
  localparam int CELL = 53;
  localparam logic [4:0] MY_ADDR = 5'd5;

  logic       clk = 1'b0;
  logic       rst_n;
  logic [4:0] cfg_port_addr;
  logic [1:0] cfg_depth;
  logic [4:0] tx_addr;
  logic       tx_enb_n, tx_soc;
  logic [7:0] tx_data;
  logic       tx_clav, tx_clav_oe, tx_clav2;
  logic       rd_valid, rd_ready, rd_soc, ovf_sticky;
  logic [7:0] rd_data;

  int checks = 0;
  int fails  = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  utp2_tx_phy u_utp2_tx_phy (
    .clk(clk), .rst_n(rst_n), .cfg_port_addr(cfg_port_addr),
    .cfg_depth(cfg_depth), .tx_addr(tx_addr), .tx_enb_n(tx_enb_n),
    .tx_soc(tx_soc), .tx_data(tx_data), .tx_clav(tx_clav),
    .tx_clav_oe(tx_clav_oe), .tx_clav2(tx_clav2), .rd_valid(rd_valid),
    .rd_ready(rd_ready), .rd_data(rd_data), .rd_soc(rd_soc),
    .ovf_sticky(ovf_sticky)
  );

  task automatic check(input bit ok, input string req, input string what,
                       input int act, input int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
    end
  endtask

  // poll an address, then look at the registered flags one clock later
  task automatic poll(input logic [4:0] a, input string req, input int exp_oe,
                      input int exp_clav, input int exp_clav2);
    @(negedge clk);
    tx_addr = a; tx_enb_n = 1'b1; tx_soc = 1'b0;
    @(negedge clk);
    check(tx_clav_oe == exp_oe, req, "clav_oe", tx_clav_oe, exp_oe);
    check(tx_clav == exp_clav, req, "clav", tx_clav, exp_clav);
    check(tx_clav2 == exp_clav2, req, "clav2", tx_clav2, exp_clav2);
  endtask

  // select address a, then push bytes first..first+n-1 of a cell with pattern seed
  task automatic push(input logic [4:0] a, input logic [7:0] seed,
                      input int first, input int n, input bit with_soc);
    @(negedge clk);
    tx_addr = a; tx_enb_n = 1'b1; tx_soc = 1'b0;
    for (int i = 0; i < n; i++) begin
      @(negedge clk);
      tx_enb_n = 1'b0;
      tx_soc   = with_soc && (i == 0);
      tx_data  = seed + 8'(first + i);
    end
    @(negedge clk);
    tx_enb_n = 1'b1; tx_soc = 1'b0; tx_addr = MY_ADDR;
  endtask

  // read bytes start..52 of a cell with pattern seed, one check per cell
  task automatic drain(input logic [7:0] seed, input int start, input string req);
    bit ok = 1'b1;
    int act = 0, exp = 0;
    @(negedge clk);
    rd_ready = 1'b1;
    for (int i = start; i < CELL; i++) begin
      if (i != start) @(negedge clk);
      if (ok && (!rd_valid || rd_data != seed + 8'(i) || rd_soc != (i == 0))) begin
        ok = 1'b0; act = rd_valid ? int'(rd_data) : -1; exp = int'(seed + 8'(i));
      end
    end
    @(negedge clk);
    rd_ready = 1'b0;
    check(ok, req, "cell byte", act, exp);
  endtask

  task automatic t_reset();
    rst_n = 1'b0;
    tx_enb_n = 1'b1; tx_soc = 1'b0; tx_data = '0; tx_addr = '0;
    rd_ready = 1'b0; cfg_port_addr = MY_ADDR; cfg_depth = 2'b10;
    repeat (3) @(negedge clk);
    check(!tx_clav && !tx_clav_oe && !tx_clav2, "R1", "flags in reset",
          {tx_clav, tx_clav_oe, tx_clav2}, 0);
    check(!rd_valid && !ovf_sticky, "R1", "valid/ovf in reset",
          {rd_valid, ovf_sticky}, 0);
    rst_n = 1'b1;
    @(negedge clk);
    check(!rd_valid, "R1", "empty after reset", rd_valid, 0);
  endtask

  task automatic t_poll();
    poll(MY_ADDR, "R2", 1, 1, 1);
    poll(5'd9, "R3", 0, 0, 1);   // R4: clav2 still driven on a miss
  endtask

  task automatic t_commit_and_pause();
    push(MY_ADDR, 8'h10, 0, 52, 1'b1);
    check(!rd_valid, "R6", "held before last byte", rd_valid, 0);
    push(MY_ADDR, 8'h10, 52, 1, 1'b0);   // R11: gap with enable high
    check(rd_valid, "R6", "visible after last byte", rd_valid, 1);
    drain(8'h10, 0, "R11");
    check(!rd_valid, "R6", "empty after drain", rd_valid, 0);
  endtask

  task automatic t_depth();
    cfg_depth = 2'b00;
    push(MY_ADDR, 8'h20, 0, CELL, 1'b1);
    poll(MY_ADDR, "R5", 1, 1, 0);
    push(MY_ADDR, 8'h40, 0, CELL, 1'b1);
    poll(MY_ADDR, "R5", 1, 0, 0);
    poll(5'd1, "R3", 0, 0, 0);
    check(!ovf_sticky, "R9", "no ovf yet", ovf_sticky, 0);
    push(MY_ADDR, 8'h60, 0, CELL, 1'b1);
    check(ovf_sticky, "R9", "ovf set", ovf_sticky, 1);
    drain(8'h20, 0, "R9");
    drain(8'h40, 0, "R9");
    check(!rd_valid, "R9", "rejected cell absent", rd_valid, 0);
    cfg_depth = 2'b01;
    push(MY_ADDR, 8'h01, 0, CELL, 1'b1);
    push(MY_ADDR, 8'h02, 0, CELL, 1'b1);
    poll(MY_ADDR, "R5", 1, 1, 0);
    push(MY_ADDR, 8'h03, 0, CELL, 1'b1);
    poll(MY_ADDR, "R5", 1, 0, 0);
    drain(8'h01, 0, "R10");
    drain(8'h02, 0, "R10");
    drain(8'h03, 0, "R10");
    cfg_depth = 2'b11;
    poll(MY_ADDR, "R5", 1, 1, 1);
  endtask

  task automatic t_unselected();
    push(5'd9, 8'h77, 0, CELL, 1'b1);
    check(!rd_valid, "R7", "other address ignored", rd_valid, 0);
    poll(MY_ADDR, "R7", 1, 1, 1);
  endtask

  task automatic t_realign();
    push(MY_ADDR, 8'hA0, 0, 20, 1'b1);
    push(MY_ADDR, 8'hB0, 0, CELL, 1'b1);
    drain(8'hB0, 0, "R8");
    check(!rd_valid, "R8", "partial discarded", rd_valid, 0);
  endtask

  task automatic t_backpressure();
    logic [7:0] d0;
    push(MY_ADDR, 8'hC3, 0, CELL, 1'b1);
    @(negedge clk);
    d0 = rd_data;
    check(rd_soc && d0 == 8'hC3, "R10", "first byte offered", d0, 8'hC3);
    repeat (3) @(negedge clk);
    check(rd_valid && rd_soc && rd_data == d0, "R10", "stall holds", rd_data, d0);
    rd_ready = 1'b1;
    @(negedge clk);
    rd_ready = 1'b0;
    repeat (2) @(negedge clk);
    check(!rd_soc && rd_data == 8'hC4, "R10", "second byte held", rd_data, 8'hC4);
    drain(8'hC3, 1, "R10");
    check(!rd_valid, "R10", "empty after drain", rd_valid, 0);
  endtask

  initial begin
    #(CLK_PERIOD * 200000);
    fails++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
    $finish;
  end

  initial begin
    t_reset();
    t_poll();
    t_commit_and_pause();
    t_depth();
    t_unselected();
    t_realign();
    t_backpressure();
    repeat (2) @(negedge clk);
    $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
    $finish;
  end

endmodule